// File: doc/BRIEF.md
# Tag-to-Reader Manchester Response Encoder

This block converts a stream of response bytes into the on/off control for a load modulator on a vicinity-card link. It runs on a clock equal to the carrier, so one clock cycle is one carrier period. A frame opens when the first byte is offered while the encoder is idle. The encoder then emits the start delimiter, each byte least significant bit first as Manchester half-bits, and the end delimiter. It stays busy until the last delimiter cycle has gone out. Checksums, response timing and the analog load switch belong to other blocks.

Two mode inputs shape the waveform. One picks a single subcarrier (carrier/32) or two subcarriers (carrier/32 and carrier/28). The other picks the high or the low data rate. Every waveform piece is a segment: an unmodulated stretch, a run of carrier/32 pulses, or a run of carrier/28 pulses. Each pulse starts high and is never cut short. A pulse train can therefore move from one subcarrier to the other with no break in phase.

Internally a frame state machine walks through the states IDLE, SOF_LEAD, SOF_BURST, SOF_ONE_A, SOF_ONE_B, BIT_A, BIT_B, EOF_ZERO_A, EOF_ZERO_B, EOF_BURST and EOF_TAIL. Each non-idle state holds exactly one segment. The transitions are:
- IDLE goes to SOF_LEAD when a byte is accepted.
- Each delimiter state goes to the next one when its segment ends.
- SOF_ONE_B goes to BIT_A.
- BIT_A goes to BIT_B.
- BIT_B goes back to BIT_A when bits remain or a new byte is accepted, and to EOF_ZERO_A otherwise.
- EOF_TAIL goes back to IDLE.

Top module: `resp_manchester_enc`

## Requirements
- R1: After reset, and whenever idle, busy=0, mod_out=0 and in_ready=1. A reset in the middle of a frame returns the block to this state at once.
- R2: A carrier/32 pulse is 16 cycles high followed by 16 cycles low. A carrier/28 pulse is 14 cycles high followed by 14 cycles low. Every segment starts a fresh pulse at its high phase.
- R3: With dual_sc=0 at high rate, a 0 bit is 8 carrier/32 pulses followed by 256 low cycles. A 1 bit is 256 low cycles followed by 8 carrier/32 pulses.
- R4: With dual_sc=1 at high rate, a 0 bit is 8 carrier/32 pulses followed by 9 carrier/28 pulses. A 1 bit is 9 carrier/28 pulses followed by 8 carrier/32 pulses.
- R5: The start delimiter depends on the subcarrier mode. With dual_sc=0 it is 768 low cycles, then 24 carrier/32 pulses, then a 1 bit. With dual_sc=1 it is 27 carrier/28 pulses, then 24 carrier/32 pulses, then a 1 bit.
- R6: The end delimiter is a 0 bit followed by 24 carrier/32 pulses. It then ends with 768 low cycles when dual_sc=0, or with 27 carrier/28 pulses when dual_sc=1.
- R7: With low_rate=1, every pulse count and low duration is four times larger. The pulse shapes of R2 are unchanged.
- R8: Bits of each byte are sent least significant bit first.
- R9: in_ready is asserted during a frame only in the last cycle of the last half-bit of a byte. A byte taken then starts in the very next cycle, with no gap.
- R10: If no byte is offered when a byte finishes, the end delimiter follows at once. One cycle after its last cycle, busy=0 and mod_out=0.
- R11: A frame starts when in_valid=1 while idle. That byte is accepted on the same edge, and busy=1 from the next cycle on.
- R12: dual_sc and low_rate are sampled when the first byte is accepted. Changing them later in the frame has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A response byte is offered |
| in_ready | output | 1 | The offered byte is taken on this edge |
| in_data | input | DATA_W | Response byte |
| dual_sc | input | 1 | 1 selects two subcarriers, 0 selects one |
| low_rate | input | 1 | 1 selects the low data rate (all counts times four) |
| busy | output | 1 | A frame is being emitted |
| mod_out | output | 1 | Load modulator control, 1 = load applied |

## Verification
The frames cover both subcarrier modes at both data rates. The bytes are chosen so that 0-to-1 and 1-to-0 bit boundaries show whether the half-bit order is right, and an asymmetric byte exposes a reversed bit order. Two-byte frames with values such as 0x01 followed by 0x80, and 0xFF followed by 0x00, test that a following byte joins without a gap and that the last bit of one byte is not merged with the first bit of the next. Every frame flips both mode inputs after its first byte, so a design that fails to hold the sampled mode produces a different waveform. Each segment is compared cycle by cycle with a waveform the bench computes on its own, so a wrong pulse width, pulse count or phase restart is caught. The directed tests cover the idle state and a reset that arrives in the middle of a frame.

// File: rtl/rsp_enc_pkg.sv
package rsp_enc_pkg;

    // Subcarrier pulse geometry in carrier cycles
    localparam int SLOW_HALF         = 16;
    localparam int FAST_HALF         = 14;
    // Pulse counts at the high data rate
    localparam int BIT_SLOW_PULSES   = 8;
    localparam int BIT_FAST_PULSES   = 9;
    localparam int DELIM_SLOW_PULSES = 24;
    localparam int DELIM_FAST_PULSES = 27;

    localparam int SLOW_BIT_CYC   = BIT_SLOW_PULSES * 2 * SLOW_HALF;
    localparam int FAST_BIT_CYC   = BIT_FAST_PULSES * 2 * FAST_HALF;
    localparam int SLOW_DELIM_CYC = DELIM_SLOW_PULSES * 2 * SLOW_HALF;
    localparam int FAST_DELIM_CYC = DELIM_FAST_PULSES * 2 * FAST_HALF;
    localparam int QUIET_BIT_CYC  = SLOW_BIT_CYC;
    localparam int QUIET_DELIM_CYC = SLOW_DELIM_CYC;

    typedef enum logic [1:0] {
        SEG_QUIET = 2'd0,
        SEG_SLOW  = 2'd1,
        SEG_FAST  = 2'd2
    } seg_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SOF_LEAD,
        ST_SOF_BURST,
        ST_SOF_ONE_A,
        ST_SOF_ONE_B,
        ST_BIT_A,
        ST_BIT_B,
        ST_EOF_ZERO_A,
        ST_EOF_ZERO_B,
        ST_EOF_BURST,
        ST_EOF_TAIL
    } frame_st_e;

endpackage

// File: rtl/rsp_seg_table.sv
module rsp_seg_table
    import rsp_enc_pkg::*;
#(
    parameter int LEN_W    = 12,
    parameter int RATE_MUL = 4
) (
    input  frame_st_e        st,
    input  logic             bit_val,
    input  logic             dual,
    input  logic             low,
    output seg_kind_e        kind,
    output logic [LEN_W-1:0] len
);

    localparam logic [LEN_W-1:0] L_SLOW_BIT   = LEN_W'(SLOW_BIT_CYC);
    localparam logic [LEN_W-1:0] L_FAST_BIT   = LEN_W'(FAST_BIT_CYC);
    localparam logic [LEN_W-1:0] L_QUIET_BIT  = LEN_W'(QUIET_BIT_CYC);
    localparam logic [LEN_W-1:0] L_SLOW_DELIM = LEN_W'(SLOW_DELIM_CYC);
    localparam logic [LEN_W-1:0] L_FAST_DELIM = LEN_W'(FAST_DELIM_CYC);
    localparam logic [LEN_W-1:0] L_QUIET_DELIM = LEN_W'(QUIET_DELIM_CYC);
    localparam logic [LEN_W-1:0] L_MUL        = LEN_W'(RATE_MUL);

    seg_kind_e        alt_kind;
    logic [LEN_W-1:0] alt_len;
    logic [LEN_W-1:0] base_len;

    // The half-bit that differs between the two subcarrier modes
    assign alt_kind = dual ? SEG_FAST : SEG_QUIET;
    assign alt_len  = dual ? L_FAST_BIT : L_QUIET_BIT;

    always_comb begin
        kind     = SEG_QUIET;
        base_len = '0;
        unique case (st)
            ST_IDLE: begin
                kind     = SEG_QUIET;
                base_len = '0;
            end
            ST_SOF_LEAD: begin
                kind     = dual ? SEG_FAST : SEG_QUIET;
                base_len = dual ? L_FAST_DELIM : L_QUIET_DELIM;
            end
            ST_SOF_BURST, ST_EOF_BURST: begin
                kind     = SEG_SLOW;
                base_len = L_SLOW_DELIM;
            end
            ST_SOF_ONE_A, ST_EOF_ZERO_B: begin
                kind     = alt_kind;
                base_len = alt_len;
            end
            ST_SOF_ONE_B, ST_EOF_ZERO_A: begin
                kind     = SEG_SLOW;
                base_len = L_SLOW_BIT;
            end
            ST_BIT_A: begin
                kind     = bit_val ? alt_kind : SEG_SLOW;
                base_len = bit_val ? alt_len : L_SLOW_BIT;
            end
            ST_BIT_B: begin
                kind     = bit_val ? SEG_SLOW : alt_kind;
                base_len = bit_val ? L_SLOW_BIT : alt_len;
            end
            ST_EOF_TAIL: begin
                kind     = dual ? SEG_FAST : SEG_QUIET;
                base_len = dual ? L_FAST_DELIM : L_QUIET_DELIM;
            end
            default: begin
                kind     = SEG_QUIET;
                base_len = '0;
            end
        endcase
    end

    assign len = low ? LEN_W'(base_len * L_MUL) : base_len;

endmodule

// File: rtl/rsp_seg_engine.sv
module rsp_seg_engine
    import rsp_enc_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int S_HALF = SLOW_HALF,
    parameter int F_HALF = FAST_HALF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  seg_kind_e        kind_in,
    input  logic [LEN_W-1:0] len_in,
    output logic             seg_last,
    output logic             mod_out
);

    localparam int MAX_HALF = (S_HALF > F_HALF) ? S_HALF : F_HALF;
    localparam int PH_W     = $clog2(2 * MAX_HALF);

    seg_kind_e        kind_q;
    logic [LEN_W-1:0] rem_q;
    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  ph_top;
    logic [PH_W-1:0]  ph_half;

    assign ph_top  = (kind_q == SEG_FAST) ? PH_W'(2 * F_HALF - 1) : PH_W'(2 * S_HALF - 1);
    assign ph_half = (kind_q == SEG_FAST) ? PH_W'(F_HALF) : PH_W'(S_HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= SEG_QUIET;
            rem_q  <= '0;
            ph_q   <= '0;
        end else if (load) begin
            kind_q <= kind_in;
            rem_q  <= len_in;
            ph_q   <= '0;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
            ph_q  <= (ph_q == ph_top) ? '0 : ph_q + 1'b1;
        end
    end

    assign seg_last = (rem_q == LEN_W'(1));
    assign mod_out  = (rem_q != '0) && (kind_q != SEG_QUIET) && (ph_q < ph_half);

endmodule

// File: rtl/rsp_frame_fsm.sv
module rsp_frame_fsm
    import rsp_enc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              dual_in,
    input  logic              low_in,
    input  logic              seg_last,
    output logic              in_ready,
    output logic              busy,
    output logic              load,
    output frame_st_e         nxt_st,
    output logic              nxt_bit,
    output logic              dual_eff,
    output logic              low_eff
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    frame_st_e         st_q;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dual_q;
    logic              low_q;
    logic              byte_end;
    logic              is_idle;

    assign is_idle  = (st_q == ST_IDLE);
    assign byte_end = (st_q == ST_BIT_B) && seg_last && (cnt_q == LAST_BIT);

    // State register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sh_q   <= '0;
            cnt_q  <= '0;
            dual_q <= 1'b0;
            low_q  <= 1'b0;
        end else begin
            st_q <= nxt_st;
            if (is_idle && in_valid) begin
                sh_q   <= in_data;
                cnt_q  <= '0;
                dual_q <= dual_in;
                low_q  <= low_in;
            end else if ((st_q == ST_BIT_B) && seg_last) begin
                if (cnt_q != LAST_BIT) begin
                    sh_q  <= sh_q >> 1;
                    cnt_q <= cnt_q + 1'b1;
                end else if (in_valid) begin
                    sh_q  <= in_data;
                    cnt_q <= '0;
                end
            end
        end
    end

    // Next state and the bit carried into it
    always_comb begin
        nxt_st  = st_q;
        nxt_bit = sh_q[0];
        unique case (st_q)
            ST_IDLE:       if (in_valid) nxt_st = ST_SOF_LEAD;
            ST_SOF_LEAD:   if (seg_last) nxt_st = ST_SOF_BURST;
            ST_SOF_BURST:  if (seg_last) nxt_st = ST_SOF_ONE_A;
            ST_SOF_ONE_A:  if (seg_last) nxt_st = ST_SOF_ONE_B;
            ST_SOF_ONE_B:  if (seg_last) nxt_st = ST_BIT_A;
            ST_BIT_A:      if (seg_last) nxt_st = ST_BIT_B;
            ST_BIT_B: begin
                if (seg_last) begin
                    if (cnt_q != LAST_BIT) begin
                        nxt_st  = ST_BIT_A;
                        nxt_bit = sh_q[1];
                    end else if (in_valid) begin
                        nxt_st  = ST_BIT_A;
                        nxt_bit = in_data[0];
                    end else begin
                        nxt_st = ST_EOF_ZERO_A;
                    end
                end
            end
            ST_EOF_ZERO_A: if (seg_last) nxt_st = ST_EOF_ZERO_B;
            ST_EOF_ZERO_B: if (seg_last) nxt_st = ST_EOF_BURST;
            ST_EOF_BURST:  if (seg_last) nxt_st = ST_EOF_TAIL;
            ST_EOF_TAIL:   if (seg_last) nxt_st = ST_IDLE;
            default:       nxt_st = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = !is_idle;
        in_ready = is_idle || byte_end;
        load     = (nxt_st != st_q) && (nxt_st != ST_IDLE);
        dual_eff = is_idle ? dual_in : dual_q;
        low_eff  = is_idle ? low_in  : low_q;
    end

endmodule

// File: rtl/resp_manchester_enc.sv
module resp_manchester_enc
    import rsp_enc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RATE_MUL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              dual_sc,
    input  logic              low_rate,
    output logic              busy,
    output logic              mod_out
);

    localparam int MAX_CYC = QUIET_DELIM_CYC * RATE_MUL;
    localparam int LEN_W   = $clog2(MAX_CYC + 1);

    frame_st_e        nxt_st;
    logic             nxt_bit;
    logic             dual_eff;
    logic             low_eff;
    logic             load;
    logic             seg_last;
    seg_kind_e        seg_kind;
    logic [LEN_W-1:0] seg_len;

    rsp_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .dual_in  (dual_sc),
        .low_in   (low_rate),
        .seg_last (seg_last),
        .in_ready (in_ready),
        .busy     (busy),
        .load     (load),
        .nxt_st   (nxt_st),
        .nxt_bit  (nxt_bit),
        .dual_eff (dual_eff),
        .low_eff  (low_eff)
    );

    rsp_seg_table #(.LEN_W(LEN_W), .RATE_MUL(RATE_MUL)) u_tab (
        .st      (nxt_st),
        .bit_val (nxt_bit),
        .dual    (dual_eff),
        .low     (low_eff),
        .kind    (seg_kind),
        .len     (seg_len)
    );

    rsp_seg_engine #(.LEN_W(LEN_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .kind_in  (seg_kind),
        .len_in   (seg_len),
        .seg_last (seg_last),
        .mod_out  (mod_out)
    );

endmodule

// File: rtl/resp_manchester_enc_chk.sv
module resp_manchester_enc_chk #(
    parameter int RATE_MUL = 4
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic mod_out
);

    localparam int LOW_LIMIT = 768 * RATE_MUL + 16;

    int hi_run;
    int lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            hi_run <= mod_out ? hi_run + 1 : 0;
            lo_run <= (busy && !mod_out) ? lo_run + 1 : 0;
        end
    end

    // R1: nothing is modulated while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mod_out);

    // R2: every high phase lasts exactly one half pulse of either subcarrier
    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_out && hi_run != 0) |-> (hi_run == 14 || hi_run == 16));

    // R5: no low stretch inside a frame exceeds the longest delimiter gap
    p_low_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_run <= LOW_LIMIT);

    // R11: a frame only starts after a byte was offered
    p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));

    // R9: an accepted byte always keeps the frame running
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

endmodule

bind resp_manchester_enc resp_manchester_enc_chk #(.RATE_MUL(RATE_MUL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .mod_out  (mod_out)
);

// File: tb/resp_manchester_enc_test.sv
module resp_manchester_enc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       dual_sc = 1'b0;
    logic       low_rate = 1'b0;
    logic       busy;
    logic       mod_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    resp_manchester_enc #(.DATA_W(8), .RATE_MUL(4)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .dual_sc  (dual_sc),
        .low_rate (low_rate),
        .busy     (busy),
        .mod_out  (mod_out)
    );

    // {dual, low, two_bytes, byte0, byte1}
    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h3C, 8'h00},
        {1'b0, 1'b0, 1'b1, 8'h01, 8'h80},
        {1'b1, 1'b0, 1'b1, 8'hFF, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h96, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h4B, 8'h00}
    };

    // Expected segments: kind 0 = unmodulated, 1 = carrier/32, 2 = carrier/28
    int    sk [64];
    int    sl [64];
    string stg[64];
    int    ns;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic add_seg(input int kind, input int len, input string tag);
        sk[ns]  = kind;
        sl[ns]  = len;
        stg[ns] = (kind != 0) ? {tag, " R2"} : tag;
        ns++;
    endtask

    task automatic build(input bit dual, input bit low, input bit two,
                         input logic [7:0] b0, input logic [7:0] b1);
        int    m;
        int    ak;
        int    al;
        string sfx;
        string dtag;
        logic [7:0] bt;
        m    = low ? 4 : 1;
        ak   = dual ? 2 : 0;
        al   = dual ? 252 * m : 256 * m;
        sfx  = low ? " R7 R12" : " R12";
        dtag = dual ? "R4 R8" : "R3 R8";
        if (two) dtag = {dtag, " R9"};
        ns = 0;
        add_seg(dual ? 2 : 0, dual ? 756 * m : 768 * m, {"R5", sfx});
        add_seg(1, 768 * m, {"R5", sfx});
        add_seg(ak, al, {"R5", sfx});
        add_seg(1, 256 * m, {"R5", sfx});
        for (int j = 0; j < (two ? 2 : 1); j++) begin
            bt = (j == 0) ? b0 : b1;
            for (int i = 0; i < 8; i++) begin
                if (bt[i]) begin
                    add_seg(ak, al, {dtag, sfx});
                    add_seg(1, 256 * m, {dtag, sfx});
                end else begin
                    add_seg(1, 256 * m, {dtag, sfx});
                    add_seg(ak, al, {dtag, sfx});
                end
            end
        end
        add_seg(1, 256 * m, {"R6", sfx});
        add_seg(ak, al, {"R6", sfx});
        add_seg(1, 768 * m, {"R6", sfx});
        add_seg(dual ? 2 : 0, dual ? 756 * m : 768 * m, {"R6 R10", sfx});
    endtask

    function automatic bit exp_out(input int kind, input int k);
        if (kind == 1) return (k % 32) < 16;
        if (kind == 2) return (k % 28) < 14;
        return 1'b0;
    endfunction

    task automatic run_frame(input bit dual, input bit low, input bit two,
                             input logic [7:0] b0, input logic [7:0] b1);
        int ptr;
        bit acc;
        bit ok;
        int bad_k;
        int bad_v;
        build(dual, low, two, b0, b1);
        @(negedge clk);
        dual_sc  = dual;
        low_rate = low;
        in_valid = 1'b1;
        in_data  = b0;
        check(in_ready == 1'b1 && busy == 1'b0, "R11", "ready while idle", in_ready, 1);
        acc = 1'b1;
        ptr = 0;
        for (int s = 0; s < ns; s++) begin
            ok    = 1'b1;
            bad_k = 0;
            bad_v = 0;
            for (int k = 0; k < sl[s]; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (acc) begin
                    ptr++;
                    if (ptr == 1) begin
                        dual_sc  = ~dual;
                        low_rate = ~low;
                    end
                    if (two && ptr == 1) in_data = b1;
                    else begin
                        in_valid = 1'b0;
                        in_data  = 8'h00;
                    end
                end
                if (ok && (mod_out !== exp_out(sk[s], k) || busy !== 1'b1)) begin
                    ok    = 1'b0;
                    bad_k = k;
                    bad_v = {busy, mod_out};
                end
                acc = in_valid && in_ready;
            end
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL %s segment %0d cycle %0d: {busy,mod_out} actual %0d expected %0d",
                         stg[s], s, bad_k, bad_v, 2 + exp_out(sk[s], bad_k));
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0 && mod_out == 1'b0 && in_ready == 1'b1, "R10",
              "idle after end delimiter {busy,mod_out}", {busy, mod_out}, 0);
        check(ptr == (two ? 2 : 1), "R9", "bytes accepted", ptr, two ? 2 : 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset and right after it
        check(busy == 1'b0 && mod_out == 1'b0, "R1", "outputs in reset", {busy, mod_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && mod_out == 1'b0 && in_ready == 1'b1, "R1",
              "idle after reset {busy,mod_out,ready}", {busy, mod_out, in_ready}, 1);
        // R11: no frame without in_valid, even with modes changing
        dual_sc  = 1'b1;
        low_rate = 1'b1;
        repeat (50) @(negedge clk);
        check(busy == 1'b0 && mod_out == 1'b0, "R11", "stays idle without valid",
              {busy, mod_out}, 0);

        for (int v = 0; v < NV; v++) begin
            run_frame(VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);
            repeat (5) @(negedge clk);
        end

        // R1: reset in the middle of a dual-subcarrier frame
        @(negedge clk);
        dual_sc  = 1'b1;
        low_rate = 1'b0;
        in_valid = 1'b1;
        in_data  = 8'h5A;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b1 && mod_out == 1'b1, "R5", "dual start pulse high {busy,mod_out}",
              {busy, mod_out}, 3);
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(busy == 1'b0 && mod_out == 1'b0 && in_ready == 1'b1, "R1",
              "mid-frame reset {busy,mod_out,ready}", {busy, mod_out, in_ready}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(busy == 1'b0 && mod_out == 1'b0, "R1", "quiet after mid-frame reset",
              {busy, mod_out}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: frames still running, actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule